// File: doc/BRIEF.md
# GPIO Port Interrupt and Debounce Unit

This unit holds the interrupt side of one GPIO port. Each pin of a parallel input vector is first synchronised. It can then pass through its own debounce filter. After that it feeds a per-pin detector that raises a status bit. The detector runs in one of two modes. In level mode the status follows the pin. In edge mode a single, chosen edge direction latches the status.

Software controls the unit through a zero-wait APB-style register port. Per-pin control words select the enable, the mask, the mode, the polarity and debounce. A write-one-to-clear register acknowledges latched edges. Software can also read the raw status and the synchronised pins. The status bits that are not masked are ORed into one registered interrupt line. A strap input selects a second register layout, in which the mask, mode, polarity, status and acknowledge words sit at other offsets.

Each pin's debounce filter is a two-state machine. The states are `DB_STEADY` (output settled) and `DB_WATCH` (input differs from the output; counting). It has these transitions:
- STEADY→WATCH when the synchronised input differs from the held output.
- WATCH→STEADY without change when the input returns to the held value.
- WATCH→STEADY with acceptance when the input has differed for `DEB_CYCLES` consecutive samples.
- WATCH→WATCH while counting.
- A forced return to STEADY, with the output tracking the input, whenever debounce is off for that pin.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset every control word (enable, mask, mode, polarity, debounce) reads 0. The status reads 0 and `irq_out` is 0.
- R2: With `alt_map`=0 the byte offsets are as follows:
  - enable 0x30, mask 0x34, mode 0x38, polarity 0x3C
  - status 0x40 (read-only), debounce 0x48
  - acknowledge 0x4C (write-only, reads 0), synchronised pins 0x50 (read-only)
  - any other offset reads 0 and ignores writes.
- R3: With `alt_map`=1 the layout changes: mode 0x34, polarity 0x38, status 0x3C, acknowledge 0x40, mask 0x44. Enable 0x30, debounce 0x48 and pins 0x50 stay where they are. 0x4C is then unmapped, and a write there clears nothing.
- R4: In level mode (mode bit 0) an enabled pin's status bit is 1 exactly while its filtered input equals its polarity bit (1 = active high, 0 = active low). The bit is not latched.
- R5: In edge mode (mode bit 1) an enabled pin latches status on a rising edge when polarity is 1, and on a falling edge when polarity is 0. The opposite edge has no effect.
- R6: Writing the acknowledge register clears the latched edge status of every pin whose written bit is 1. Pins whose written bit is 0 keep their status.
- R7: A pin whose enable bit is 0 reads status 0 and discards any latched edge, so re-enabling it shows no stale status.
- R8: A mask bit of 1 keeps that pin out of `irq_out`, while its status bit still reads as pending.
- R9: `irq_out` is a register equal to the OR of (status AND NOT mask) from the previous cycle.
- R10: For a pin with its debounce bit set, a change of the synchronised input reaches the detector only after it has been seen on `DEB_CYCLES` (default 4) consecutive clocks. Shorter pulses are dropped.
- R11: Debounce is per pin: a pin without its debounce bit reacts without the filter delay, whatever other pins use.
- R12: The pins register returns `pin_in` delayed by a two-flop synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alt_map | input | 1 | Layout strap: 0 default offsets, 1 relocated offsets |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 write, 0 read |
| paddr | input | ADDR_W | Byte offset |
| pwdata | input | NPIN | Write data, one bit per pin |
| prdata | output | NPIN | Read data, valid in the access phase |
| pin_in | input | NPIN | Asynchronous pin inputs |
| irq_out | output | 1 | Combined registered interrupt |

## Verification
Take a pin change driven just after clock edge 0. The synchronised value appears after edge 2. A level status bit is readable from then on, and `irq_out` follows at edge 3. An edge status latches at edge 3 and `irq_out` rises at edge 4. With debounce on, the filtered value moves at edge 6, so a level interrupt is due at edge 7. A register write commits on the access-phase edge, and its effect on `irq_out` is due one edge later. The bench queues each expected `irq_out` value with the exact cycle it is due, including the cycle just before it must change. A monitor compares them at the falling edge, so early and late responses both fail.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_ENABLE,
        SEL_MASK,
        SEL_MODE,
        SEL_POL,
        SEL_STATUS,
        SEL_DEBOUNCE,
        SEL_ACK,
        SEL_PINS
    } reg_sel_e;

    typedef enum logic {
        DB_STEADY,
        DB_WATCH
    } db_state_e;

    // Offsets shared by both layouts are tested first; the rest depend on the strap.
    function automatic reg_sel_e decode_offset(input logic [7:0] ofs, input logic alt);
        reg_sel_e sel;
        sel = SEL_NONE;
        if (ofs == 8'h30) begin
            sel = SEL_ENABLE;
        end else if (ofs == 8'h48) begin
            sel = SEL_DEBOUNCE;
        end else if (ofs == 8'h50) begin
            sel = SEL_PINS;
        end else if (!alt) begin
            case (ofs)
                8'h34:   sel = SEL_MASK;
                8'h38:   sel = SEL_MODE;
                8'h3C:   sel = SEL_POL;
                8'h40:   sel = SEL_STATUS;
                8'h4C:   sel = SEL_ACK;
                default: sel = SEL_NONE;
            endcase
        end else begin
            case (ofs)
                8'h34:   sel = SEL_MODE;
                8'h38:   sel = SEL_POL;
                8'h3C:   sel = SEL_STATUS;
                8'h40:   sel = SEL_ACK;
                8'h44:   sel = SEL_MASK;
                default: sel = SEL_NONE;
            endcase
        end
        return sel;
    endfunction

endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NPIN   = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alt_map,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [NPIN-1:0]   pwdata,
    output logic [NPIN-1:0]   prdata,
    input  logic [NPIN-1:0]   status,
    input  logic [NPIN-1:0]   pin_sync,
    output logic [NPIN-1:0]   ctl_en,
    output logic [NPIN-1:0]   ctl_mask,
    output logic [NPIN-1:0]   ctl_type,
    output logic [NPIN-1:0]   ctl_pol,
    output logic [NPIN-1:0]   ctl_deb,
    output logic [NPIN-1:0]   ack_clr
);

    logic     hi_ok;
    logic     wr_fire;
    reg_sel_e sel;

    // Offsets above the low byte must be zero (ADDR_W >= 8).
    generate
        if (ADDR_W > 8) begin : g_hi_check
            assign hi_ok = ~|paddr[ADDR_W-1:8];
        end else begin : g_no_hi
            assign hi_ok = 1'b1;
        end
    endgenerate

    assign sel     = hi_ok ? decode_offset(paddr[7:0], alt_map) : SEL_NONE;
    assign wr_fire = psel & penable & pwrite;
    assign ack_clr = (wr_fire && sel == SEL_ACK) ? pwdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_en   <= '0;
            ctl_mask <= '0;
            ctl_type <= '0;
            ctl_pol  <= '0;
            ctl_deb  <= '0;
        end else if (wr_fire) begin
            case (sel)
                SEL_ENABLE:   ctl_en   <= pwdata;
                SEL_MASK:     ctl_mask <= pwdata;
                SEL_MODE:     ctl_type <= pwdata;
                SEL_POL:      ctl_pol  <= pwdata;
                SEL_DEBOUNCE: ctl_deb  <= pwdata;
                default:      ;
            endcase
        end
    end

    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            case (sel)
                SEL_ENABLE:   prdata = ctl_en;
                SEL_MASK:     prdata = ctl_mask;
                SEL_MODE:     prdata = ctl_type;
                SEL_POL:      prdata = ctl_pol;
                SEL_DEBOUNCE: prdata = ctl_deb;
                SEL_STATUS:   prdata = status;
                SEL_PINS:     prdata = pin_sync;
                default:      prdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_irq_filter.sv
module gpio_irq_filter
    import gpio_irq_pkg::*;
#(
    parameter int DEB_CYCLES = 4   // accepted range: 2 and above
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    input  logic deb_on,
    output logic pin_sync,
    output logic pin_clean
);

    localparam int CNT_W = $clog2(DEB_CYCLES + 1);

    logic             meta_q;
    logic             sync_q;
    logic             held_q, held_d;
    db_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= pin_raw;
            sync_q <= meta_q;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DB_STEADY;
            cnt_q   <= '0;
            held_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            held_q  <= held_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        held_d  = held_q;
        if (!deb_on) begin
            state_d = DB_STEADY;
            cnt_d   = '0;
            held_d  = sync_q;
        end else begin
            unique case (state_q)
                DB_STEADY: begin
                    if (sync_q != held_q) begin
                        state_d = DB_WATCH;
                        cnt_d   = CNT_W'(1);
                    end
                end
                DB_WATCH: begin
                    if (sync_q == held_q) begin
                        state_d = DB_STEADY;
                        cnt_d   = '0;
                    end else if (cnt_q == CNT_W'(DEB_CYCLES - 1)) begin
                        state_d = DB_STEADY;
                        cnt_d   = '0;
                        held_d  = sync_q;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        pin_sync  = sync_q;
        pin_clean = deb_on ? held_q : sync_q;
    end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int NPIN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_clean,
    input  logic [NPIN-1:0] ctl_en,
    input  logic [NPIN-1:0] ctl_mask,
    input  logic [NPIN-1:0] ctl_type,
    input  logic [NPIN-1:0] ctl_pol,
    input  logic [NPIN-1:0] ack_clr,
    output logic [NPIN-1:0] status,
    output logic [NPIN-1:0] edge_hit,
    output logic [NPIN-1:0] edge_lat,
    output logic            irq_out
);

    logic [NPIN-1:0] prev_q;
    logic [NPIN-1:0] rise, fall, level_act, edge_arm;
    logic            irq_q;

    always_comb begin
        edge_arm  = ctl_en & ctl_type;
        rise      = pin_clean & ~prev_q;
        fall      = ~pin_clean & prev_q;
        edge_hit  = edge_arm & ((ctl_pol & rise) | (~ctl_pol & fall));
        level_act = ctl_en & ~ctl_type & ~(pin_clean ^ ctl_pol);
        status    = (edge_lat & edge_arm) | level_act;
        irq_out   = irq_q;
    end

    // A new edge in the same cycle as its acknowledge wins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q   <= '0;
            edge_lat <= '0;
            irq_q    <= 1'b0;
        end else begin
            prev_q   <= pin_clean;
            edge_lat <= ((edge_lat & ~ack_clr) | edge_hit) & edge_arm;
            irq_q    <= |(status & ~ctl_mask);
        end
    end

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
    parameter int NPIN       = 32,
    parameter int ADDR_W     = 8,
    parameter int DEB_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alt_map,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [NPIN-1:0]   pwdata,
    output logic [NPIN-1:0]   prdata,
    input  logic [NPIN-1:0]   pin_in,
    output logic              irq_out
);

    logic [NPIN-1:0] ctl_en, ctl_mask, ctl_type, ctl_pol, ctl_deb, ack_clr;
    logic [NPIN-1:0] pin_sync, pin_clean, status, edge_hit, edge_lat;

    gpio_irq_regs #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .alt_map  (alt_map),
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .paddr    (paddr),
        .pwdata   (pwdata),
        .prdata   (prdata),
        .status   (status),
        .pin_sync (pin_sync),
        .ctl_en   (ctl_en),
        .ctl_mask (ctl_mask),
        .ctl_type (ctl_type),
        .ctl_pol  (ctl_pol),
        .ctl_deb  (ctl_deb),
        .ack_clr  (ack_clr)
    );

    generate
        for (genvar i = 0; i < NPIN; i++) begin : g_pin
            gpio_irq_filter #(.DEB_CYCLES(DEB_CYCLES)) u_filter (
                .clk       (clk),
                .rst_n     (rst_n),
                .pin_raw   (pin_in[i]),
                .deb_on    (ctl_deb[i]),
                .pin_sync  (pin_sync[i]),
                .pin_clean (pin_clean[i])
            );
        end
    endgenerate

    gpio_irq_detect #(.NPIN(NPIN)) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_clean (pin_clean),
        .ctl_en    (ctl_en),
        .ctl_mask  (ctl_mask),
        .ctl_type  (ctl_type),
        .ctl_pol   (ctl_pol),
        .ack_clr   (ack_clr),
        .status    (status),
        .edge_hit  (edge_hit),
        .edge_lat  (edge_lat),
        .irq_out   (irq_out)
    );

endmodule

// File: rtl/gpio_irq_checker.sv
module gpio_irq_checker #(
    parameter int NPIN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            irq_out,
    input logic [NPIN-1:0] status,
    input logic [NPIN-1:0] ctl_en,
    input logic [NPIN-1:0] ctl_mask,
    input logic [NPIN-1:0] ctl_type,
    input logic [NPIN-1:0] ctl_deb,
    input logic [NPIN-1:0] ack_clr,
    input logic [NPIN-1:0] edge_hit,
    input logic [NPIN-1:0] edge_lat,
    input logic [NPIN-1:0] pin_sync,
    input logic [NPIN-1:0] pin_clean
);

    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (irq_out == 1'b0 && edge_lat == '0);
        end
    end

    a_r9_irq_registered: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_out == $past(|(status & ~ctl_mask)));

    a_r5_latch_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (edge_lat & ~$past(edge_lat) & ~$past(edge_hit)) == '0);

    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (edge_lat & $past(ack_clr & ~edge_hit)) == '0);

    a_r7_disable_drops: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (edge_lat & ~$past(ctl_en & ctl_type)) == '0);

    a_r10_debounce_hold: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pin_clean ^ $past(pin_clean)) & ctl_deb & $past(ctl_deb)
                  & (($past(pin_sync) ^ pin_clean) | ($past(pin_sync, 2) ^ pin_clean))) == '0);

endmodule

bind gpio_irq_unit gpio_irq_checker #(.NPIN(NPIN)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_out   (irq_out),
    .status    (status),
    .ctl_en    (ctl_en),
    .ctl_mask  (ctl_mask),
    .ctl_type  (ctl_type),
    .ctl_deb   (ctl_deb),
    .ack_clr   (ack_clr),
    .edge_hit  (edge_hit),
    .edge_lat  (edge_lat),
    .pin_sync  (pin_sync),
    .pin_clean (pin_clean)
);

// File: tb/tb_gpio_irq_unit.sv
module tb_gpio_irq_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NPIN       = 32;
    localparam int ADDR_W     = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              alt_map = 1'b0;
    logic              psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [ADDR_W-1:0] paddr = '0;
    logic [NPIN-1:0]   pwdata = '0;
    logic [NPIN-1:0]   prdata;
    logic [NPIN-1:0]   pins = '0;
    logic              irq_out;

    int  n_checks = 0;
    int  n_fail   = 0;
    int  cyc      = 0;
    bit  finished = 1'b0;

    int    due_q[$];
    bit    val_q[$];
    string tag_q[$];

    gpio_irq_unit #(.NPIN(NPIN), .ADDR_W(ADDR_W), .DEB_CYCLES(4)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .alt_map (alt_map),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .prdata  (prdata),
        .pin_in  (pins),
        .irq_out (irq_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare each queued irq expectation in its due cycle.
    always @(negedge clk) begin
        while (due_q.size() > 0 && due_q[0] <= cyc) begin
            n_checks++;
            if (irq_out !== val_q[0]) begin
                n_fail++;
                $display("FAIL %s irq_out at cycle %0d: got %b expected %b", tag_q[0], cyc, irq_out, val_q[0]);
            end
            void'(due_q.pop_front());
            void'(val_q.pop_front());
            void'(tag_q.pop_front());
        end
    end

    task automatic sched_irq(input int delay, input bit v, input string tag);
        due_q.push_back(cyc + delay);
        val_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic apb_write(input logic [7:0] a, input logic [NPIN-1:0] d);
        @(posedge clk); #1;
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(posedge clk); #1;
        penable = 1'b1;
        @(posedge clk); #1;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic check_reg(input logic [7:0] a, input logic [NPIN-1:0] exp, input string tag);
        logic [NPIN-1:0] got;
        @(posedge clk); #1;
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        @(posedge clk); #1;
        penable = 1'b1;
        #1 got = prdata;
        @(posedge clk); #1;
        psel = 1'b0; penable = 1'b0;
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s read 0x%02h: got 0x%08h expected 0x%08h", tag, a, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state
        sched_irq(0, 1'b0, "R1");
        check_reg(8'h30, '0, "R1");
        check_reg(8'h34, '0, "R1");
        check_reg(8'h38, '0, "R1");
        check_reg(8'h3C, '0, "R1");
        check_reg(8'h40, '0, "R1");
        check_reg(8'h48, '0, "R1");

        // R12: synchronised pins readback
        pins = 32'hA5A5_0F0F;
        idle(3);
        check_reg(8'h50, 32'hA5A5_0F0F, "R12");
        pins = '0;
        idle(3);

        // R2: default layout
        apb_write(8'h34, 32'h0000_00F0);
        apb_write(8'h38, 32'h0000_0F00);
        apb_write(8'h3C, 32'h0000_F000);
        apb_write(8'h48, 32'h000F_0000);
        check_reg(8'h34, 32'h0000_00F0, "R2");
        check_reg(8'h38, 32'h0000_0F00, "R2");
        check_reg(8'h3C, 32'h0000_F000, "R2");
        check_reg(8'h48, 32'h000F_0000, "R2");
        check_reg(8'h44, '0, "R2");
        check_reg(8'h4C, '0, "R2");
        apb_write(8'h34, '0);
        apb_write(8'h38, '0);
        apb_write(8'h3C, '0);
        apb_write(8'h48, '0);

        // R4: level mode, pin0 active high, pin1 active low
        apb_write(8'h3C, 32'h1);
        apb_write(8'h30, 32'h3);
        sched_irq(1, 1'b1, "R4");
        idle(2);
        check_reg(8'h40, 32'h2, "R4");
        pins[1] = 1'b1;
        sched_irq(3, 1'b0, "R4");
        idle(4);
        check_reg(8'h40, 32'h0, "R4");
        pins[0] = 1'b1;
        sched_irq(2, 1'b0, "R9");
        sched_irq(3, 1'b1, "R9");
        idle(4);
        check_reg(8'h40, 32'h1, "R4");
        pins[0] = 1'b0;
        sched_irq(3, 1'b0, "R4");
        idle(4);
        check_reg(8'h40, 32'h0, "R4");
        apb_write(8'h30, '0);
        apb_write(8'h3C, '0);
        pins = '0;
        idle(3);

        // R5 / R6: pin2 rising edge, latched, acknowledged
        apb_write(8'h38, 32'h4);
        apb_write(8'h3C, 32'h4);
        apb_write(8'h30, 32'h4);
        pins[2] = 1'b1;
        sched_irq(3, 1'b0, "R5");
        sched_irq(4, 1'b1, "R5");
        idle(5);
        check_reg(8'h40, 32'h4, "R5");
        pins[2] = 1'b0;
        idle(4);
        check_reg(8'h40, 32'h4, "R5");
        apb_write(8'h4C, 32'h0);
        sched_irq(1, 1'b1, "R6");
        check_reg(8'h40, 32'h4, "R6");
        apb_write(8'h4C, 32'h4);
        sched_irq(1, 1'b0, "R6");
        check_reg(8'h40, 32'h0, "R6");
        // R5: falling polarity ignores the rising edge
        apb_write(8'h3C, 32'h0);
        pins[2] = 1'b1;
        sched_irq(4, 1'b0, "R5");
        idle(5);
        check_reg(8'h40, 32'h0, "R5");
        pins[2] = 1'b0;
        sched_irq(4, 1'b1, "R5");
        idle(5);
        apb_write(8'h4C, 32'hFFFF_FFFF);
        sched_irq(1, 1'b0, "R6");
        check_reg(8'h40, 32'h0, "R6");

        // R7: disabling discards a latched edge
        pins[2] = 1'b1;
        idle(4);
        pins[2] = 1'b0;
        idle(5);
        check_reg(8'h40, 32'h4, "R7");
        apb_write(8'h30, 32'h0);
        sched_irq(1, 1'b0, "R7");
        check_reg(8'h40, 32'h0, "R7");
        apb_write(8'h30, 32'h4);
        sched_irq(1, 1'b0, "R7");
        check_reg(8'h40, 32'h0, "R7");
        apb_write(8'h30, '0);
        apb_write(8'h38, '0);
        idle(2);

        // R8: mask blocks irq but not status
        apb_write(8'h3C, 32'h1);
        apb_write(8'h30, 32'h1);
        apb_write(8'h34, 32'h1);
        pins[0] = 1'b1;
        sched_irq(3, 1'b0, "R8");
        sched_irq(6, 1'b0, "R8");
        idle(6);
        check_reg(8'h40, 32'h1, "R8");
        apb_write(8'h34, 32'h0);
        sched_irq(1, 1'b1, "R8");
        idle(2);
        pins[0] = 1'b0;
        sched_irq(3, 1'b0, "R8");
        idle(4);
        apb_write(8'h30, '0);
        apb_write(8'h3C, '0);

        // R10: debounce on pin3
        apb_write(8'h3C, 32'h8);
        apb_write(8'h48, 32'h8);
        apb_write(8'h30, 32'h8);
        pins[3] = 1'b1;
        idle(2);
        pins[3] = 1'b0;
        sched_irq(4, 1'b0, "R10");
        sched_irq(8, 1'b0, "R10");
        idle(9);
        check_reg(8'h40, 32'h0, "R10");
        pins[3] = 1'b1;
        sched_irq(6, 1'b0, "R10");
        sched_irq(7, 1'b1, "R10");
        idle(8);
        pins[3] = 1'b0;
        sched_irq(6, 1'b1, "R10");
        sched_irq(7, 1'b0, "R10");
        idle(8);

        // R11: pin4 undebounced beside debounced pin3
        apb_write(8'h3C, 32'h18);
        apb_write(8'h30, 32'h18);
        pins[4:3] = 2'b11;
        sched_irq(2, 1'b0, "R11");
        sched_irq(3, 1'b1, "R11");
        idle(8);
        pins[4:3] = 2'b00;
        sched_irq(5, 1'b1, "R11");
        sched_irq(7, 1'b0, "R11");
        idle(8);
        apb_write(8'h30, '0);
        apb_write(8'h3C, '0);
        apb_write(8'h48, '0);

        // R3: alternate layout
        alt_map = 1'b1;
        check_reg(8'h44, '0, "R3");
        apb_write(8'h44, 32'h0000_F0F0);
        check_reg(8'h44, 32'h0000_F0F0, "R3");
        alt_map = 1'b0;
        check_reg(8'h34, 32'h0000_F0F0, "R3");
        alt_map = 1'b1;
        apb_write(8'h34, 32'h4);
        apb_write(8'h38, 32'h0);
        apb_write(8'h30, 32'h4);
        pins[2] = 1'b1;
        idle(4);
        pins[2] = 1'b0;
        idle(5);
        check_reg(8'h3C, 32'h4, "R3");
        apb_write(8'h4C, 32'h4);
        check_reg(8'h3C, 32'h4, "R3");
        apb_write(8'h40, 32'h4);
        check_reg(8'h3C, 32'h0, "R3");
        check_reg(8'h34, 32'h4, "R3");

        idle(10);
        finish_run();
    end

endmodule